// File: doc/BRIEF.md
# Split-Column Signed Multiplier

This block multiplies two two's-complement operands of `N` bits (8 by default) and returns the full `2N`-bit signed product. It forms every partial-product bit in parallel with AND gates and applies the sign-correction scheme that lets signed numbers pass through an unsigned compression tree. That scheme inverts selected bits, adds a constant one at column `N` and flips the result's top bit.

The partial-product field is then cut into two column halves of equal width. The low half covers columns `0..N-1` and the high half covers columns `N..2N-1`. Each half is compressed by its own carry-save tree until two rows remain, and those two rows are added. The two trees share no logic, so neither tree's depth waits on the other. The low half's sum gives the low product bits directly. Its overflow bits are then added into the high half's sum to give the upper product bits.

An optional operand register stage (`IN_REG`, on by default) captures the operands on the rising clock edge. The product is combinational from the captured operands.

Top module: `bw_mul_split`

## Requirements
- R1: For every pair of signed operands, `prod` equals the exact two's-complement product `op_a * op_b` as a `2N`-bit signed value.
- R2: The low `N` bits of `prod` equal the low `N` bits of the operand product. They are taken unchanged from the low column half's sum, and that sum never exceeds `(N-1)*2^N + 1`.
- R3: The most negative value times itself gives the positive value `2^(2N-2)`; for `N=8`, -128 times -128 gives +16384 (0x4000).
- R4: When either captured operand is zero, `prod` is zero.
- R5: With `IN_REG=1`, `prod` reflects the operands present at the most recent rising clock edge, one cycle after they are applied.
- R6: While `rst_n` is low, the captured operands are held at zero, so `prod` reads zero whatever `op_a` and `op_b` carry.
- R7: The sign extremes come out exact. For `N=8`: 127 times 127 gives 16129, -128 times 127 gives -16256, and -1 times -1 gives 1.
- R8: With `IN_REG=1`, a change of `op_a` or `op_b` between rising edges leaves `prod` unchanged until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the operand register stage |
| rst_n | input | 1 | Active-low asynchronous reset of the operand registers |
| op_a | input | N | Signed multiplicand |
| op_b | input | N | Signed multiplier |
| prod | output | 2N | Signed product |

## Verification
The low half's overflow into bits `N..N+2` is added in the same evaluation as the high half's own carry, the column-`N` constant and the top-bit flip. A fault in any of these four shows up only for particular operand pairs. The bench therefore sweeps all 65536 operand pairs, with a new pair each cycle, and compares each product with the integer product that the bench computes itself. Operand capture and a mid-cycle operand change also fall in one clock period. These are provoked by altering the operands between edges and checking that the output holds its value until the next edge.

// File: rtl/bw_mul_pkg.sv
package bw_mul_pkg;

   // rows left after one level of 3:2 counters over a set of r rows
   function automatic int next_rows(input int r);
      return 2 * (r / 3) + (r % 3);
   endfunction

   // rows present at a given level of the tree
   function automatic int rows_at(input int r0, input int lvl);
      int r;
      r = r0;
      for (int k = 0; k < lvl; k++) r = next_rows(r);
      return r;
   endfunction

   // number of counter levels needed to reach two rows
   function automatic int tree_levels(input int r0);
      int r;
      int l;
      r = r0;
      l = 0;
      while (r > 2) begin
         r = next_rows(r);
         l++;
      end
      return l;
   endfunction

endpackage

// File: rtl/bw_ppgen.sv
module bw_ppgen #(
   parameter int N  = 8,
   parameter int W0 = 11
) (
   input  logic [N-1:0]  a,
   input  logic [N-1:0]  b,
   output logic [W0-1:0] lo_rows [N],
   output logic [N-1:0]  hi_rows [N+1]
);
   if (W0 < N + 1) begin : g_bad_w0
      $error("bw_ppgen: W0 must exceed N");
   end

   always_comb begin
      for (int i = 0; i < N; i++) begin
         lo_rows[i] = '0;
         hi_rows[i] = '0;
      end
      // sign-correction constant at column N
      hi_rows[N] = N'(1);
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            logic bit_v;
            // row top bits flip, last row flips below its top, corner stays
            bit_v = (a[j] & b[i]) ^ ((j == N-1) ^ (i == N-1));
            if (i + j < N) lo_rows[i][i+j]   = bit_v;
            else           hi_rows[i][i+j-N] = bit_v;
         end
      end
   end
endmodule

// File: rtl/bw_fa_row.sv
module bw_fa_row #(
   parameter int W = 8
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic [W-1:0] z,
   output logic [W-1:0] s,
   output logic [W-1:0] c
);
   if (W < 2) begin : g_bad_w
      $error("bw_fa_row: W must be at least 2");
   end

   assign s = x ^ y ^ z;
   // carries move one column up; the one past the top is dropped (mod 2^W)
   assign c = {(x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) | (y[W-2:0] & z[W-2:0]), 1'b0};
endmodule

// File: rtl/bw_csa_tree.sv
module bw_csa_tree
   import bw_mul_pkg::*;
#(
   parameter int W    = 8,
   parameter int ROWS = 8
) (
   input  logic [W-1:0] rows_i [ROWS],
   output logic [W-1:0] sum_o
);
   localparam int LEVELS = tree_levels(ROWS);

   if (ROWS < 2) begin : g_bad_rows
      $error("bw_csa_tree: ROWS must be at least 2");
   end

   for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
      localparam int RN = rows_at(ROWS, l);
      logic [W-1:0] row [RN];
      if (l == 0) begin : g_in
         for (genvar r = 0; r < RN; r++) begin : g_cp
            assign row[r] = rows_i[r];
         end
      end else begin : g_red
         localparam int RP = rows_at(ROWS, l - 1);
         localparam int NG = RP / 3;
         for (genvar g = 0; g < NG; g++) begin : g_fa
            bw_fa_row #(.W(W)) u_fa (
               .x (g_lvl[l-1].row[3*g]),
               .y (g_lvl[l-1].row[3*g+1]),
               .z (g_lvl[l-1].row[3*g+2]),
               .s (row[2*g]),
               .c (row[2*g+1])
            );
         end
         for (genvar k = 0; k < RP % 3; k++) begin : g_pass
            assign row[2*NG+k] = g_lvl[l-1].row[3*NG+k];
         end
      end
   end

   // two-row carry-propagate add; structure left to the adder library
   assign sum_o = g_lvl[LEVELS].row[0] + g_lvl[LEVELS].row[1];
endmodule

// File: rtl/bw_mul_split.sv
module bw_mul_split #(
   parameter int N      = 8,
   parameter bit IN_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N-1:0]      op_a,
   input  logic [N-1:0]      op_b,
   output logic [2*N-1:0]    prod
);
   localparam int W0     = N + $clog2(N);
   localparam int LO_MAX = (N - 1) * (1 << N) + 1;

   if (N < 3 || N > 16) begin : g_bad_n
      $error("bw_mul_split: N must lie in 3..16");
   end

   logic [N-1:0] a_q;
   logic [N-1:0] b_q;

   if (IN_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
         end else begin
            a_q <= op_a;
            b_q <= op_b;
         end
      end

      AST_CAPTURE_A: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> a_q == $past(op_a)); // R5
      AST_CAPTURE_B: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> b_q == $past(op_b)); // R5
      AST_HOLD_PROD: assert property (@(negedge clk) disable iff (!rst_n)
         $stable(a_q) && $stable(b_q) |-> $stable(prod)); // R8
   end else begin : g_comb
      assign a_q = op_a;
      assign b_q = op_b;
   end

   logic [W0-1:0] lo_rows [N];
   logic [N-1:0]  hi_rows [N+1];
   logic [W0-1:0] lo_sum;
   logic [N-1:0]  hi_sum;
   logic [N-1:0]  hi_byte;

   bw_ppgen #(.N(N), .W0(W0)) u_pp (
      .a       (a_q),
      .b       (b_q),
      .lo_rows (lo_rows),
      .hi_rows (hi_rows)
   );

   bw_csa_tree #(.W(W0), .ROWS(N)) u_lo (
      .rows_i (lo_rows),
      .sum_o  (lo_sum)
   );

   bw_csa_tree #(.W(N), .ROWS(N + 1)) u_hi (
      .rows_i (hi_rows),
      .sum_o  (hi_sum)
   );

   // low half overflow meets high half sum, modulo 2^N
   assign hi_byte = N'(lo_sum[W0-1:N]) + hi_sum;
   assign prod    = {~hi_byte[N-1], hi_byte[N-2:0], lo_sum[N-1:0]};

   AST_PRODUCT_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      prod == ($signed({{N{a_q[N-1]}}, a_q}) * $signed({{N{b_q[N-1]}}, b_q}))); // R1
   AST_LOW_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      prod[N-1:0] == N'(a_q * b_q)); // R2
   AST_LOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      lo_sum <= W0'(LO_MAX)); // R2
   AST_MIN_SQUARE: assert property (@(posedge clk) disable iff (!rst_n)
      (a_q == {1'b1, {(N-1){1'b0}}}) && (b_q == {1'b1, {(N-1){1'b0}}})
      |-> prod == (2*N)'(1) << (2*N-2)); // R3
   AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
      (a_q == '0) || (b_q == '0) |-> prod == '0); // R4
endmodule

// File: tb/test_bw_mul_split.sv
module test_bw_mul_split;
   localparam int N = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   op_a = '0;
   logic [N-1:0]   op_b = '0;
   logic [2*N-1:0] prod;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   bw_mul_split #(.N(N), .IN_REG(1'b1)) i_bw_mul_split (
      .clk   (clk),
      .rst_n (rst_n),
      .op_a  (op_a),
      .op_b  (op_b),
      .prod  (prod)
   );

   task automatic check(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: prod=%h expected %h (a=%0d b=%0d)", req, act, exp,
                  $signed(op_a), $signed(op_b));
      end
   endtask

   function automatic logic [2*N-1:0] ref_mul(input int x, input int y);
      return (2*N)'(x * y);
   endfunction

   // apply a pair, wait one full cycle, compare
   task automatic apply(input string req, input int x, input int y, input logic [2*N-1:0] exp);
      op_a = N'(x);
      op_b = N'(y);
      @(negedge clk);
      check(req, prod, exp);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      // R6: reset holds the product at zero despite live operands
      op_a = 8'd5;
      op_b = 8'd7;
      repeat (3) @(negedge clk);
      check("R6 reset with operands", prod, '0);
      op_a = 8'h80;
      op_b = 8'h81;
      @(negedge clk);
      check("R6 reset after operand change", prod, '0);
      rst_n = 1'b1;

      // R5: one-cycle latency
      op_a = 8'd3;
      op_b = 8'd4;
      @(negedge clk);
      check("R5 captured after one edge", prod, 16'd12);

      // R8: mid-cycle change is not visible before the next edge
      op_a = 8'd100;
      op_b = 8'hF6;
      #1;
      check("R8 held before edge", prod, 16'd12);
      @(negedge clk);
      check("R8 updated after edge", prod, ref_mul(100, -10));

      // R3, R4, R7 corner pairs
      apply("R3 min times min", -128, -128, 16'h4000);
      apply("R4 zero multiplicand", 0, -77, 16'h0000);
      apply("R4 zero multiplier", -128, 0, 16'h0000);
      apply("R7 max times max", 127, 127, 16'd16129);
      apply("R7 min times max", -128, 127, ref_mul(-128, 127));
      apply("R7 minus one squared", -1, -1, 16'd1);

      // R1 and R2: every operand pair, one pair per cycle
      for (int i = -128; i < 128; i++) begin
         for (int j = -128; j < 128; j++) begin
            op_a = N'(i);
            op_b = N'(j);
            @(negedge clk);
            check("R1 full product", prod, ref_mul(i, j));
            checks++;
            if (prod[N-1:0] !== ref_mul(i, j)[N-1:0]) begin
               errors++;
               $display("FAIL R2 low byte: prod=%h expected %h", prod[N-1:0], ref_mul(i, j)[N-1:0]);
            end
         end
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule